// File: doc/BRIEF.md
# Backup Battery Load-Test Scheduler

This block decides when a backup cell is put under a test load and keeps track of whether that cell has been judged worn out. A free-running tick timebase drives every interval it uses. After the main supply becomes good and a recovery interval has passed, the block runs a test. During the test it raises an enable that connects an external load to the cell. While that enable is high, it watches a comparator flag that reports the loaded cell voltage as below its trip level.

A test fails if the comparator flag is seen high on any clock of the window. A failed test pulls the active-low warning output low. The next test is then scheduled on a short warning cadence instead of the long normal one, so that a fresh cell is noticed quickly. A later passing test releases the warning, but only if the cell was detached for a minimum time after the warning was set. A shorter detach does not count as a replacement.

Loss of supply stops all testing at once and keeps the warning as it is. Every return of supply brings a new test after recovery, whether or not the warning was already set. All intervals are parameters counted in ticks.

Top module: `batt_test_sched`

## Requirements
- R1: While `rst_n` is low, `warn_n` is 1 (no warning) and `load_en` is 0. Reset is synchronous.
- R2: While `supply_ok` is 0, `load_en` stays 0. When `supply_ok` rises, `load_en` rises once RECOV_TICKS ticks have passed: with a tick on every clock, on the (RECOV_TICKS+1)-th clock after the first clock that sees `supply_ok` high.
- R3: Each test holds `load_en` high for exactly PULSE_TICKS ticks.
- R4: A test fails if `batt_low` is 1 on any clock while `load_en` is 1, including only the last clock. A failed test drives `warn_n` to 0 on the clock that ends the window.
- R5: From the end of one test window to the start of the next there are NORMAL_TICKS ticks when `warn_n` is 1 after the verdict, and WARN_TICKS ticks when `warn_n` is 0.
- R6: A passing test drives `warn_n` back to 1 only if `batt_present` was 0 for at least DETACH_TICKS consecutive ticks while the warning was set. Once cleared, the normal cadence applies.
- R7: A detach shorter than DETACH_TICKS ticks gives no credit. A passing test after it leaves `warn_n` at 0.
- R8: When `supply_ok` falls, `load_en` is 0 on the next clock and `warn_n` keeps its value. Every return of supply brings a new test after recovery, including when the warning is set.
- R9: Timers advance only on clocks where `tick` is 1. A clock without a tick delays the schedule by exactly one clock.
- R10: A failing test while the warning is set cancels any detach credit already gathered. A later pass then needs a new detach.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-clock timebase strobe |
| supply_ok | input | 1 | Main supply within tolerance |
| batt_low | input | 1 | Comparator: loaded cell below trip level |
| batt_present | input | 1 | Cell detected in its holder |
| load_en | output | 1 | Connects the test load to the cell |
| warn_n | output | 1 | Active-low worn-cell warning |

## Verification
The bench puts a low comparator reading in only the first clock of a window, and later in only the last clock. A design that sampled once, or sampled too late, would miss one of these and leave the warning released. It also runs detaches one tick short of and exactly at the minimum length. A design with an off-by-one detach count, or one that cleared the warning on any pass, would release the warning on the short detach. A failing retest placed after a full detach checks that the credit is dropped; a design that kept it would clear the warning on the next pass. Supply loss in the middle of a window, a power-up retest with the warning already set, and a pause in the tick stream complete the corner cases. A design that kept testing without supply, skipped the retest, or counted clocks instead of ticks would show wrong window timing or wrong gaps.

// File: rtl/bts_pkg.sv
package bts_pkg;

  typedef enum logic [1:0] {
    ST_OFF     = 2'd0,
    ST_RECOVER = 2'd1,
    ST_LOAD    = 2'd2,
    ST_GAP     = 2'd3
  } bts_state_t;

  // Interval between windows, chosen by the warning state after the verdict.
  function automatic int unsigned gap_ticks(input logic warned,
                                            input int unsigned normal_t,
                                            input int unsigned warn_t);
    return warned ? warn_t : normal_t;
  endfunction

  // Largest of the interval parameters, used to size the shared counter.
  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/bts_tick_timer.sv
module bts_tick_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  input  logic [W-1:0] lim,
  output logic         done
);
  logic [W-1:0] cnt;

  assign done = adv && !clr && (cnt == lim - W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (done)     cnt <= '0;
    else if (adv)      cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/bts_detach_watch.sv
module bts_detach_watch #(
  parameter int unsigned DETACH_TICKS = 2,
  localparam int unsigned DW = $clog2(DETACH_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic warned,
  input  logic batt_present,
  input  logic cancel,
  output logic rearm
);
  logic [DW-1:0] run;
  logic          reached;

  assign reached = tick && !batt_present && (run == DW'(DETACH_TICKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !warned || cancel) begin
      run   <= '0;
      rearm <= 1'b0;
    end else begin
      if (batt_present)  run <= '0;
      else if (tick && !rearm && !reached) run <= run + DW'(1);
      if (reached) rearm <= 1'b1;
    end
  end
endmodule

// File: rtl/batt_test_sched.sv
module batt_test_sched
  import bts_pkg::*;
#(
  parameter int unsigned NORMAL_TICKS = 86400,
  parameter int unsigned WARN_TICKS   = 5,
  parameter int unsigned PULSE_TICKS  = 1,
  parameter int unsigned RECOV_TICKS  = 1,
  parameter int unsigned DETACH_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic supply_ok,
  input  logic batt_low,
  input  logic batt_present,
  output logic load_en,
  output logic warn_n
);
  localparam int unsigned MAXT = max4(NORMAL_TICKS, WARN_TICKS, PULSE_TICKS, RECOV_TICKS);
  localparam int unsigned CW   = $clog2(MAXT + 1);

  bts_state_t    state, state_nx;
  logic [CW-1:0] lim;
  logic          tmr_clr, tmr_adv, tmr_done;
  logic          fail_q, warned;

  // Named internal events, observed by the checker.
  logic test_done, verdict_fail, rearm, fail_event, clear_event;

  assign test_done    = (state == ST_LOAD) && tmr_done && supply_ok;
  assign verdict_fail = fail_q || batt_low;
  assign fail_event   = test_done && verdict_fail;
  assign clear_event  = test_done && !verdict_fail && rearm;

  always_comb begin
    unique case (state)
      ST_RECOVER: lim = CW'(RECOV_TICKS);
      ST_LOAD:    lim = CW'(PULSE_TICKS);
      ST_GAP:     lim = CW'(gap_ticks(warned, NORMAL_TICKS, WARN_TICKS));
      default:    lim = CW'(1);
    endcase
  end

  assign tmr_clr = !supply_ok || (state == ST_OFF);
  assign tmr_adv = tick && (state != ST_OFF);

  bts_tick_timer #(.W(CW)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (tmr_clr),
    .adv  (tmr_adv),
    .lim  (lim),
    .done (tmr_done)
  );

  bts_detach_watch #(.DETACH_TICKS(DETACH_TICKS)) u_detach (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .warned      (warned),
    .batt_present(batt_present),
    .cancel      (fail_event),
    .rearm       (rearm)
  );

  always_comb begin
    state_nx = state;
    if (!supply_ok) state_nx = ST_OFF;
    else begin
      unique case (state)
        ST_OFF:     state_nx = ST_RECOVER;
        ST_RECOVER: if (tmr_done) state_nx = ST_LOAD;
        ST_LOAD:    if (tmr_done) state_nx = ST_GAP;
        ST_GAP:     if (tmr_done) state_nx = ST_LOAD;
        default:    state_nx = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_OFF;
      fail_q <= 1'b0;
      warned <= 1'b0;
    end else begin
      state <= state_nx;
      if (state != ST_LOAD || test_done || !supply_ok) fail_q <= 1'b0;
      else if (batt_low)                                fail_q <= 1'b1;
      if (fail_event)       warned <= 1'b1;
      else if (clear_event) warned <= 1'b0;
    end
  end

  assign load_en = (state == ST_LOAD);
  assign warn_n  = !warned;
endmodule

// File: rtl/bts_checker.sv
module bts_checker (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic supply_ok,
  input logic load_en,
  input logic warn_n,
  input logic rearm,
  input logic test_done
);
  // R1
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (warn_n && !load_en));

  // R2
  a_r2_start_needs_supply: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_en) |-> $past(supply_ok));

  // R4
  a_r4_warn_at_window_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(warn_n) |-> ($fell(load_en) && $past(test_done)));

  // R6
  a_r6_clear_needs_detach: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warn_n) |-> ($fell(load_en) && $past(rearm)));

  // R8
  a_r8_loss_stops_load: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !load_en);

  // R8
  a_r8_loss_keeps_warn: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> $stable(warn_n));

  // R9
  a_r9_no_tick_no_move: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && supply_ok) |=> $stable(load_en));
endmodule

bind batt_test_sched bts_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .supply_ok(supply_ok),
  .load_en  (load_en),
  .warn_n   (warn_n),
  .rearm    (rearm),
  .test_done(test_done)
);

// File: tb/batt_test_sched_tb.sv
module batt_test_sched_tb;
  localparam int NORM = 20, WRN = 6, PUL = 2, REC = 3, DET = 4;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, supply_ok = 1'b0;
  logic batt_low = 1'b0, batt_present = 1'b1;
  logic load_en, warn_n;
  int checks = 0, errors = 0, cyc = 0;

  always #2 clk = ~clk;

  batt_test_sched #(.NORMAL_TICKS(NORM), .WARN_TICKS(WRN), .PULSE_TICKS(PUL),
                    .RECOV_TICKS(REC), .DETACH_TICKS(DET)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok),
    .batt_low(batt_low), .batt_present(batt_present),
    .load_en(load_en), .warn_n(warn_n));

  // Vector: low pattern per window clock [10:9], detach length in gap [8:6],
  // expected warn_n after window [5], expected gap length in clocks [4:0].
  localparam logic [10:0] VEC [8] = '{
    {2'b00, 3'd0, 1'b1, 5'd20},  // R3 R5: pass, normal cadence
    {2'b10, 3'd0, 1'b0, 5'd6},   // R4: low only in last clock, warning cadence
    {2'b00, 3'd3, 1'b0, 5'd6},   // R7: pass without detach, then short detach
    {2'b00, 3'd4, 1'b0, 5'd6},   // R7: short detach gave no credit; full detach
    {2'b00, 3'd0, 1'b1, 5'd20},  // R6: pass after full detach clears
    {2'b01, 3'd4, 1'b0, 5'd6},   // R4: low only in first clock; full detach
    {2'b11, 3'd0, 1'b0, 5'd6},   // R10: failing retest drops the credit
    {2'b00, 3'd0, 1'b0, 5'd6}    // R10: pass without new detach keeps warning
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_window(input logic [1:0] pat, output int len);
    len = 0;
    while (load_en && len < 100) begin
      batt_low = (len < 2) ? pat[len] : 1'b0;
      len++;
      @(negedge clk);
    end
    batt_low = 1'b0;
  endtask

  task automatic run_gap(input int det, input int hold, output int gap);
    gap = 0;
    while (!load_en && gap < 200) begin
      batt_present = (gap < det) ? 1'b0 : 1'b1;
      tick         = (gap < hold) ? 1'b0 : 1'b1;
      gap++;
      @(negedge clk);
    end
    batt_present = 1'b1;
    tick = 1'b1;
  endtask

  task automatic wait_rise(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!load_en && n < 200);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, len, gap, seen;
    repeat (3) @(negedge clk);
    check("R1 warn_n", warn_n, 1);
    check("R1 load_en", load_en, 0);
    rst_n = 1'b1;
    seen = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (load_en) seen++;
    end
    check("R2 no test without supply", seen, 0);

    supply_ok = 1'b1;
    wait_rise(n);
    check("R2 first test after recovery", n, REC + 1);

    for (int v = 0; v < 8; v++) begin
      run_window(VEC[v][10:9], len);
      check("R3 window length", len, PUL);
      check("R4 R6 R7 R10 warn_n", warn_n, int'(VEC[v][5]));
      run_gap(int'(VEC[v][8:6]), 0, gap);
      check("R5 gap length", gap, int'(VEC[v][4:0]));
    end

    // Supply lost in the middle of a window; warning is held.
    @(negedge clk);
    check("R3 in window before loss", load_en, 1);
    supply_ok = 1'b0;
    @(negedge clk);
    check("R8 load off after loss", load_en, 0);
    check("R8 warn held on loss", warn_n, 0);
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (load_en) seen++;
    end
    check("R2 idle while supply down", seen, 0);
    check("R8 warn held while down", warn_n, 0);

    supply_ok = 1'b1;
    wait_rise(n);
    check("R8 retest on power-up with warning", n, REC + 1);
    run_window(2'b00, len);
    check("R3 window after power-up", len, PUL);
    check("R7 pass without detach keeps warning", warn_n, 0);

    // Tick pause in the gap stretches it clock for clock.
    run_gap(0, 5, gap);
    check("R9 gap with 5 missing ticks", gap, WRN + 5);

    // Full detach during the gap, then a pass clears and restores cadence.
    run_window(2'b00, len);
    run_gap(DET, 0, gap);
    check("R5 warn cadence", gap, WRN);
    run_window(2'b00, len);
    check("R6 clear after detach", warn_n, 1);
    run_gap(0, 0, gap);
    check("R6 normal cadence restored", gap, NORM);

    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1 load_en after late reset", load_en, 0);
    check("R1 warn_n after late reset", warn_n, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule